// File: doc/BRIEF.md
# Routed Timestamp Capture Unit

The block holds four capture units that timestamp events on a bank of 32 input channels. Each unit watches one channel chosen by a packed select field in a control register. When that channel rises, the unit stores the present value of a shared, free-running timestamp count in its own first-in first-out store. Software drains each store through a dedicated data register. Every read pops one entry, and a read of an empty store returns zero.

Inputs are brought into the clock domain by a shared synchronizer. Each unit then picks its channel from the synchronized vector and detects rising edges. Any write to the control register loads a new routing and clears all four units at once. After that clear a unit waits until its channel has been seen low before it can capture again. The same applies after the hard reset. The timestamp counter itself and the bus protocol that drives the register port lie outside the block.

Top module: `ts_capture_router`

## Requirements
- R1: The control register at address 10 holds one 5-bit channel select per unit. Unit 0 uses bits 4..0, unit 1 bits 9..5, unit 2 bits 14..10 and unit 3 bits 19..15. A unit captures only from the channel its field names.
- R2: A unit stores `ts_count` once for each low-to-high transition of its selected channel. The stored value is the one present at the third rising clock edge after the input changes (two synchronizer stages, then the edge detector). A channel held high causes no further captures.
- R3: Each unit's store holds 16 entries of 32 bits and returns them in the order they were captured.
- R4: When a store is full, new events are dropped and the 16 entries already held are kept unchanged.
- R5: A read at address 12, 13, 14 or 15 returns the oldest entry of unit 0, 1, 2 or 3 on `reg_rdata` one cycle after the read strobe, and removes that entry.
- R6: A read of an empty store returns 0 and changes nothing.
- R7: Any write to address 10 empties all four stores and loads the new routing. A read at address 10 returns the last value written.
- R8: After a control write or a hard reset, a unit does not capture until its selected channel has been seen low. A channel already high at that time is not counted as an edge.
- R9: After hard reset, all stores are empty, the control register is 0 and `reg_rdata` is 0.
- R10: Several units may select the same channel, and each of them captures the same event.
- R11: A read at any address other than 10 and 12..15 returns 0 and pops no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timestamp count advances in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Register number for a read or write |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after `reg_rd` |
| chan_in | input | 32 | Asynchronous event channels |
| ts_count | input | 32 | Shared timestamp count to record |

## Verification
Read data is due one cycle after the read strobe. The bench therefore raises the strobe at a falling edge and samples `reg_rdata` at the next falling edge. A capture lands at the third rising edge after a channel changes. In the latency test the bench changes `ts_count` just before that edge, so a capture one cycle early or late stores a different value. In every other test the bench holds `ts_count` steady across the whole pulse and leaves eight cycles before reading, so those results do not depend on the exact cycle of capture.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
   localparam int REG_W = 32;

   // one-hot style address match helper used by the register decode
   function automatic logic addr_is(input logic [5:0] addr, input int unsigned target);
      return (32'(addr) == target);
   endfunction
endpackage

// File: rtl/ts_in_sync.sv
module ts_in_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_async,
   output logic [N-1:0] d_sync
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "ts_in_sync: STAGES must be at least 2");
   end

   logic [N-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ts_edge_arm.sv
module ts_edge_arm #(
   parameter int N_CH  = 32,
   parameter int SEL_W = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [N_CH-1:0]  chan_sync,
   input  logic [SEL_W-1:0] sel,
   output logic             push
);
   logic level;
   logic prev_q;

   assign level = chan_sync[sel];

   // prev_q starts high, so a channel must first be seen low (arming)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev_q <= 1'b1;
      else if (clr) prev_q <= 1'b1;
      else          prev_q <= level;
   end

   assign push = level & ~prev_q & ~clr;

   // R2: a capture only follows a cycle in which the selected level was low
   p_rise_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !$past(level));

   // R8: the cycle after a clear never captures
   p_armed_after_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !push);
endmodule

// File: rtl/ts_cap_fifo.sv
module ts_cap_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $fatal(1, "ts_cap_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wptr_q, rptr_q;
   logic [AW:0]  count;
   logic         do_push, do_pop;

   assign count   = wptr_q - rptr_q;
   assign empty   = (count == '0);
   assign full    = (count == (AW+1)'(DEPTH));
   assign do_push = push & ~full & ~clr;
   assign do_pop  = pop & ~empty & ~clr;
   assign head    = mem[rptr_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr_q[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else if (clr) begin
         wptr_q <= '0;
         rptr_q <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + 1'b1;
         if (do_pop)  rptr_q <= rptr_q + 1'b1;
      end
   end

   // R4: a full store with no pop stays full and keeps its fill level
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> (full && count == $past(count)));

   // R7: a clear leaves the store empty
   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

   // R5: a lone pop removes exactly one entry
   p_pop_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push && !clr) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/ts_capture_router.sv
module ts_capture_router #(
   parameter int N_CH        = 32,
   parameter int UNITS       = 4,
   parameter int TS_W        = 32,
   parameter int DEPTH       = 16,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int CTRL_ADDR   = 10,
   parameter int DATA_BASE   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [N_CH-1:0]   chan_in,
   input  logic [TS_W-1:0]   ts_count
);
   import ts_cap_pkg::*;

   localparam int SEL_W = $clog2(N_CH);

   initial begin
      assert (UNITS * SEL_W <= REG_W)
         else $fatal(1, "ts_capture_router: select fields exceed control width");
      assert (TS_W <= REG_W)
         else $fatal(1, "ts_capture_router: timestamp wider than data path");
      assert (ADDR_W == 6)
         else $fatal(1, "ts_capture_router: decode written for 6-bit addresses");
      assert (DATA_BASE + UNITS <= (1 << ADDR_W) && CTRL_ADDR < DATA_BASE)
         else $fatal(1, "ts_capture_router: register map does not fit");
   end

   logic [REG_W-1:0] ctrl_q;
   logic             clr;
   logic [N_CH-1:0]  chan_sync;
   logic [UNITS-1:0] hit, empty, pop;
   logic [TS_W-1:0]  head [UNITS];
   logic [31:0]      rdata_d;

   assign clr = reg_wr && addr_is(reg_addr, CTRL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ctrl_q <= '0;
      else if (clr) ctrl_q <= reg_wdata;
   end

   ts_in_sync #(.N(N_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (chan_in),
      .d_sync  (chan_sync)
   );

   generate
      for (genvar u = 0; u < UNITS; u++) begin : g_unit
         logic push;

         assign hit[u] = reg_rd && addr_is(reg_addr, DATA_BASE + u);
         assign pop[u] = hit[u];

         ts_edge_arm #(.N_CH(N_CH), .SEL_W(SEL_W)) u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .chan_sync (chan_sync),
            .sel       (ctrl_q[u*SEL_W +: SEL_W]),
            .push      (push)
         );

         ts_cap_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .push  (push),
            .din   (ts_count),
            .pop   (pop[u]),
            .head  (head[u]),
            .empty (empty[u]),
            .full  ()
         );

         // R6: reading an empty store yields zero
         p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[u] && empty[u] && !clr) |=> (reg_rdata == '0));
      end
   endgenerate

   always_comb begin
      rdata_d = '0;
      if (reg_rd && addr_is(reg_addr, CTRL_ADDR)) rdata_d = ctrl_q;
      for (int u = 0; u < UNITS; u++) begin
         if (hit[u] && !empty[u]) rdata_d = 32'(head[u]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_rdata <= '0;
      else        reg_rdata <= rdata_d;
   end

   // R11: at most one store is addressed by a read
   p_single_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pop));
endmodule

// File: tb/ts_capture_router_test.sv
module ts_capture_router_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  reg_addr;
   logic        reg_wr, reg_rd;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [31:0] chan_in;
   logic [31:0] ts_count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   ts_capture_router uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .chan_in(chan_in), .ts_count(ts_count)
   );

   // vector: unit[38:37], channel[36:32], timestamp[31:0]
   localparam int NV = 6;
   localparam logic [38:0] VEC [NV] = '{
      {2'd0, 5'd3,  32'h1111_0003},
      {2'd1, 5'd0,  32'h2222_0000},
      {2'd2, 5'd31, 32'h3333_001F},
      {2'd3, 5'd17, 32'h4444_0011},
      {2'd0, 5'd31, 32'hDEAD_BEEF},
      {2'd3, 5'd0,  32'h0000_0001}
   };

   function automatic logic [31:0] route(input logic [4:0] c0, c1, c2, c3);
      return {12'd0, c3, c2, c1, c0};
   endfunction

   task automatic check(input logic [31:0] act, exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      check(reg_rdata, exp, req);
   endtask

   task automatic pulse(input int ch, input logic [31:0] ts);
      ts_count = ts;
      chan_in[ch] = 1'b1;
      repeat (4) @(negedge clk);
      chan_in[ch] = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
      reg_wdata = '0; chan_in = '0; ts_count = '0;
      repeat (3) @(negedge clk);
      // R9: state after reset
      check(reg_rdata, 32'd0, "R9 rdata after reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      rd_chk(6'd10, 32'd0, "R9 control after reset");
      for (int u = 0; u < 4; u++) rd_chk(6'(12 + u), 32'd0, "R9 R6 empty after reset");

      // R1 R2 R5 R6: table walk
      for (int i = 0; i < NV; i++) begin
         logic [1:0]  un  = VEC[i][38:37];
         logic [4:0]  ch  = VEC[i][36:32];
         logic [31:0] ts  = VEC[i][31:0];
         logic [4:0]  oth = ch ^ 5'd1;
         logic [4:0]  f [4];
         for (int k = 0; k < 4; k++) f[k] = (k == int'(un)) ? ch : oth;
         wr_reg(6'd10, route(f[0], f[1], f[2], f[3]));
         repeat (3) @(negedge clk);
         pulse(int'(ch), ts);
         rd_chk(6'(12 + int'(un)), ts, "R1 R5 routed capture");
         rd_chk(6'(12 + int'(un)), 32'd0, "R2 R6 single capture then empty");
         for (int k = 0; k < 4; k++)
            if (k != int'(un)) rd_chk(6'(12 + k), 32'd0, "R1 unrouted unit empty");
      end

      // R2: exact capture cycle
      wr_reg(6'd10, route(5'd9, 5'd30, 5'd30, 5'd30));
      repeat (3) @(negedge clk);
      ts_count = 32'hA0A0_0001;
      chan_in[9] = 1'b1;
      @(negedge clk);
      ts_count = 32'hA0A0_0002;
      @(negedge clk);
      ts_count = 32'hA0A0_0003;
      @(negedge clk);
      ts_count = 32'hA0A0_0004;
      repeat (6) @(negedge clk);
      chan_in[9] = 1'b0;
      repeat (4) @(negedge clk);
      rd_chk(6'd12, 32'hA0A0_0003, "R2 value at third edge");
      rd_chk(6'd12, 32'd0, "R2 held high gives one capture");

      // R3 R4: order and overflow
      wr_reg(6'd10, route(5'd5, 5'd30, 5'd30, 5'd30));
      repeat (3) @(negedge clk);
      for (int i = 0; i < 20; i++) pulse(5, 32'(100 + i));
      for (int i = 0; i < 16; i++) rd_chk(6'd12, 32'(100 + i), "R3 R4 order and kept entries");
      rd_chk(6'd12, 32'd0, "R4 overflow events dropped");

      // R7: control write flushes and reads back
      for (int i = 0; i < 3; i++) pulse(5, 32'(500 + i));
      wr_reg(6'd10, route(5'd5, 5'd6, 5'd30, 5'd30));
      repeat (2) @(negedge clk);
      rd_chk(6'd12, 32'd0, "R7 flush on control write");
      rd_chk(6'd10, route(5'd5, 5'd6, 5'd30, 5'd30), "R7 control readback");

      // R8: high across the write is not an edge
      chan_in[6] = 1'b1;
      repeat (5) @(negedge clk);
      wr_reg(6'd10, route(5'd30, 5'd6, 5'd30, 5'd30));
      ts_count = 32'h0BAD_0BAD;
      repeat (10) @(negedge clk);
      rd_chk(6'd13, 32'd0, "R8 no capture until seen low");
      chan_in[6] = 1'b0;
      repeat (4) @(negedge clk);
      pulse(6, 32'h600D_0006);
      rd_chk(6'd13, 32'h600D_0006, "R8 capture after arming");

      // R10: shared channel
      wr_reg(6'd10, route(5'd7, 5'd7, 5'd7, 5'd7));
      repeat (3) @(negedge clk);
      pulse(7, 32'h7777_7777);
      for (int u = 0; u < 4; u++) rd_chk(6'(12 + u), 32'h7777_7777, "R10 shared channel");

      // R11: other addresses return 0 and pop nothing
      pulse(7, 32'h1234_5678);
      rd_chk(6'd5,  32'd0, "R11 unmapped read");
      rd_chk(6'd11, 32'd0, "R11 gap read");
      rd_chk(6'd16, 32'd0, "R11 above data range");
      rd_chk(6'd12, 32'h1234_5678, "R11 entry not popped");

      done = 1'b1;
      finish_run();
   end
endmodule